// File: doc/BRIEF.md
# Masked Bank Number Generator with Folding

This block turns a program's bank selection into the physical bank address lines of a multi-program cartridge. Each request carries the CPU address, the user bank register and four mask registers: an AND and an XOR mask for the program space, and another pair for the picture space. The block forms the 8-bit bank number as (user AND and-mask) XOR xor-mask. Two overrides apply to the program bank. A fixed-upper-bank control bit makes reads in the top 16K use an all-ones user value. A supervisor window at 0x5000-0x5FFF acts as if both program masks were zero.

The 8-bit result is then folded down to the number of bank lines that are fitted. The fold ORs groups of result bits in a pattern chosen by a 2-bit subtype. It does not just drop the upper bits. The two high bits of a 4-bit submapper code pick the program pattern, and the two low bits pick the picture pattern. When no picture ROM bank lines are fitted but picture RAM is present, the picture result instead chooses between RAM and ROM.

Requests come in on a valid/ready channel and leave through a one-entry response register. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its response appears on the next cycle. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response and `req_ready` stay frozen. The configuration pins are plain levels that are expected to be static.

Top module: `mbank_gen`

## Requirements
- R1: For CPU addresses outside 0x5000-0x5FFF, and not covered by R3, the program bank equals fold((user AND prg_and) XOR prg_xor), one cycle after the request is accepted.
- R2: The picture bank equals fold((user AND chr_and) XOR chr_xor) for every request, whatever its CPU address.
- R3: When `req_fixed_upper` is 1 and the CPU address is 0xC000 or above, the program bank uses 0xFF in place of the user value. Addresses 0x8000-0xBFFF are not affected, and the bit has no effect when it is 0.
- R4: For CPU addresses 0x5000-0x5FFF, the program bank is computed with both program masks taken as zero, which gives bank 0 at every fitted width. The picture bank is unaffected.
- R5: The program fold subtype is submapper bits [3:2] and the picture fold subtype is submapper bits [1:0].
- R6: Width 0 gives bank 0. Width 1 gives bank bit 0 as the OR of all eight result bits, for subtypes 0 and 1. Width 8 passes the result through unchanged.
- R7: Width 2, subtype 0: bank bit 1 is the OR of result bits 7,5,3,1, and bank bit 0 is the OR of bits 6,4,2,0. Width 2, subtype 1: bank bit 1 is the OR of bits 7..4, and bank bit 0 is the OR of bits 3..0.
- R8: Widths 3 to 7, subtypes 0 and 1, use these OR-groups, listed from the top bank bit down. w3s0 {7,0}{6,4,2}{5,3,1}. w3s1 {7,2}{6,4,1}{5,3,0}. w4s0 {7,3}{6,2}{5,1}{4,0}. w4s1 {7,5}{6,4}{3,1}{2,0}. w5s0 {7}{3}{6,2}{5,1}{4,0}. w5s1 {7}{0}{6,4}{5,3}{2,1}. w6s0 {7}{6}{5}{4,2}{3,1}{0}. w6s1 {7}{6}{5,3}{4,2}{1}{0}. w7s0 {7}{6}{5}{4,3}{2}{1}{0}. w7s1 {7}{6,5}{4}{3}{2}{1}{0}.
- R9: Subtypes 2 and 3 at widths 1-7 truncate to the low result bits. A width code above 8 acts as width 8. Bank bits at or above the width are always 0.
- R10: `rsp_chr_ram` is 1 only when the picture width is 0, `chr_ram_fitted` is 1, the picture subtype is 0, and the picture result is nonzero. Otherwise it is 0.
- R11: A response stays valid and unchanged while `rsp_ready` is low. `req_ready` equals (not `rsp_valid`) or `rsp_ready`.
- R12: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prg_rom_bits | input | 4 | Number of program bank lines fitted (0-8; above 8 acts as 8) |
| chr_rom_bits | input | 4 | Number of picture ROM bank lines fitted |
| submapper | input | 4 | [3:2] program fold subtype, [1:0] picture fold subtype |
| chr_ram_fitted | input | 1 | Picture RAM is present |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_cpu_addr | input | 16 | CPU address of the access |
| req_user | input | 8 | User bank register |
| req_prg_and | input | 8 | Program AND mask |
| req_prg_xor | input | 8 | Program XOR mask |
| req_chr_and | input | 8 | Picture AND mask |
| req_chr_xor | input | 8 | Picture XOR mask |
| req_fixed_upper | input | 1 | Fixed-upper-bank control bit |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_prg_bank | output | 8 | Folded program bank address |
| rsp_chr_bank | output | 8 | Folded picture bank address |
| rsp_chr_ram | output | 1 | Picture access selects RAM |

## Verification
The hardest case to reach is a single fold group that contains exactly one set bit. Only that case shows whether each bank bit ORs the right result bits, because a wrong group still gives the right answer when all or none of its bits are set. The bench therefore sets the and-mask to zero and walks a one-hot pattern through the XOR mask. This places any chosen result directly on the fold input. The walk runs for every width and subtype, and each answer is compared against an independently written reference fold. The back-pressure case is reached by holding `rsp_ready` low while a second request is already waiting.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
  localparam int BANK_W = 8;
  localparam int WCNT_W = 4;
  localparam int SUB_W  = 2;
  localparam int CPU_AW = 16;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [WCNT_W-1:0] wcnt_t;
  typedef logic [SUB_W-1:0]  sub_t;

  // OR-group mask feeding bank bit k for width w and subtype s
  function automatic bank_t fold_mask(input wcnt_t w, input sub_t s, input int k);
    bank_t m;
    m = bank_t'(1) << k;
    if (k >= int'(w)) begin
      m = '0;
    end else if (int'(w) == BANK_W) begin
      m = bank_t'(1) << k;
    end else if (s < 2) begin
      case (w)
        4'd1: m = 8'hFF;
        4'd2: case (k)
                1: m = s[0] ? 8'hF0 : 8'hAA;
                default: m = s[0] ? 8'h0F : 8'h55;
              endcase
        4'd3: case (k)
                2: m = s[0] ? 8'h84 : 8'h81;
                1: m = s[0] ? 8'h52 : 8'h54;
                default: m = s[0] ? 8'h29 : 8'h2A;
              endcase
        4'd4: case (k)
                3: m = s[0] ? 8'hA0 : 8'h88;
                2: m = s[0] ? 8'h50 : 8'h44;
                1: m = s[0] ? 8'h0A : 8'h22;
                default: m = s[0] ? 8'h05 : 8'h11;
              endcase
        4'd5: case (k)
                4: m = 8'h80;
                3: m = s[0] ? 8'h01 : 8'h08;
                2: m = s[0] ? 8'h50 : 8'h44;
                1: m = s[0] ? 8'h28 : 8'h22;
                default: m = s[0] ? 8'h06 : 8'h11;
              endcase
        4'd6: case (k)
                5: m = 8'h80;
                4: m = 8'h40;
                3: m = s[0] ? 8'h28 : 8'h20;
                2: m = 8'h14;
                1: m = s[0] ? 8'h02 : 8'h0A;
                default: m = 8'h01;
              endcase
        4'd7: case (k)
                6: m = 8'h80;
                5: m = s[0] ? 8'h60 : 8'h40;
                4: m = s[0] ? 8'h10 : 8'h20;
                3: m = s[0] ? 8'h08 : 8'h18;
                default: m = bank_t'(1) << k;
              endcase
        default: m = bank_t'(1) << k;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/mbank_mix.sv
module mbank_mix
  import mbank_pkg::*;
(
  input  bank_t user,
  input  bank_t and_mask,
  input  bank_t xor_mask,
  input  logic  force_ones,
  input  logic  zero_masks,
  output bank_t raw
);
  bank_t u_eff, a_eff, x_eff;

  always_comb begin
    u_eff = force_ones ? '1 : user;
    a_eff = zero_masks ? '0 : and_mask;
    x_eff = zero_masks ? '0 : xor_mask;
    raw   = (u_eff & a_eff) ^ x_eff;
  end
endmodule

// File: rtl/mbank_fold.sv
module mbank_fold
  import mbank_pkg::*;
(
  input  bank_t raw,
  input  wcnt_t width,
  input  sub_t  sub,
  output bank_t bank
);
  wcnt_t w_eff;

  assign w_eff = (width > wcnt_t'(BANK_W)) ? wcnt_t'(BANK_W) : width;

  for (genvar k = 0; k < BANK_W; k++) begin : g_bit
    assign bank[k] = |(raw & fold_mask(w_eff, sub, k));
  end

  // R9
  always_comb begin
    if (!$isunknown({bank, w_eff}) && int'(w_eff) < BANK_W)
      upper_zero_chk: assert ((bank >> w_eff) == '0)
        else $error("bank bits above width are set");
  end
endmodule

// File: rtl/mbank_gen.sv
module mbank_gen
  import mbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  prg_rom_bits,
  input  logic [3:0]  chr_rom_bits,
  input  logic [3:0]  submapper,
  input  logic        chr_ram_fitted,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_cpu_addr,
  input  logic [7:0]  req_user,
  input  logic [7:0]  req_prg_and,
  input  logic [7:0]  req_prg_xor,
  input  logic [7:0]  req_chr_and,
  input  logic [7:0]  req_chr_xor,
  input  logic        req_fixed_upper,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_prg_bank,
  output logic [7:0]  rsp_chr_bank,
  output logic        rsp_chr_ram
);
  localparam logic [3:0] SUP_PAGE = 4'h5;

  logic  in_sup, in_fixed, take;
  bank_t prg_raw, chr_raw, prg_fold, chr_fold;
  sub_t  prg_sub, chr_sub;
  logic  ram_nxt;

  assign prg_sub  = submapper[3:2];
  assign chr_sub  = submapper[1:0];
  assign in_sup   = (req_cpu_addr[CPU_AW-1 -: 4] == SUP_PAGE);
  assign in_fixed = req_fixed_upper && (req_cpu_addr[CPU_AW-1 -: 2] == 2'b11);

  mbank_mix prg_mix_i (
    .user(req_user), .and_mask(req_prg_and), .xor_mask(req_prg_xor),
    .force_ones(in_fixed), .zero_masks(in_sup), .raw(prg_raw)
  );
  mbank_mix chr_mix_i (
    .user(req_user), .and_mask(req_chr_and), .xor_mask(req_chr_xor),
    .force_ones(1'b0), .zero_masks(1'b0), .raw(chr_raw)
  );
  mbank_fold prg_fold_i (.raw(prg_raw), .width(prg_rom_bits), .sub(prg_sub), .bank(prg_fold));
  mbank_fold chr_fold_i (.raw(chr_raw), .width(chr_rom_bits), .sub(chr_sub), .bank(chr_fold));

  assign ram_nxt   = (chr_rom_bits == '0) && chr_ram_fitted && (chr_sub == '0) && (|chr_raw);
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_prg_bank <= '0;
      rsp_chr_bank <= '0;
      rsp_chr_ram  <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (take) begin
        rsp_prg_bank <= prg_fold;
        rsp_chr_bank <= chr_fold;
        rsp_chr_ram  <= ram_nxt;
      end
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_prg_bank)
      && $stable(rsp_chr_bank) && $stable(rsp_chr_ram));

  // R11
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R4
  sup_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_cpu_addr[15:12] == 4'h5 |=> rsp_prg_bank == '0);

  // R10
  ram_needs_nowidth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_chr_ram |-> rsp_chr_bank == '0);
endmodule

// File: tb/mbank_gen_tb_top.sv
module mbank_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] prg_rom_bits = 4'd8, chr_rom_bits = 4'd8, submapper = 4'd0;
  logic chr_ram_fitted = 1'b0;
  logic req_valid = 1'b0, req_ready, rsp_valid, rsp_ready = 1'b1, rsp_chr_ram;
  logic [15:0] req_cpu_addr = 16'h8000;
  logic [7:0] req_user = 0, req_prg_and = 0, req_prg_xor = 0, req_chr_and = 0, req_chr_xor = 0;
  logic req_fixed_upper = 1'b0;
  logic [7:0] rsp_prg_bank, rsp_chr_bank;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbank_gen dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_fold(input logic [7:0] r, input int w, input int s);
    int we = (w > 8) ? 8 : w;
    if (we == 0) return 8'h00;
    if (we == 8) return r;
    if (s >= 2) return r & ((8'h01 << we) - 8'h01);
    case (we)
      1: return {7'b0, |r};
      2: return s ? {6'b0, |r[7:4], |r[3:0]}
                  : {6'b0, r[7]|r[5]|r[3]|r[1], r[6]|r[4]|r[2]|r[0]};
      3: return s ? {5'b0, r[7]|r[2], r[6]|r[4]|r[1], r[5]|r[3]|r[0]}
                  : {5'b0, r[7]|r[0], r[6]|r[4]|r[2], r[5]|r[3]|r[1]};
      4: return s ? {4'b0, r[7]|r[5], r[6]|r[4], r[3]|r[1], r[2]|r[0]}
                  : {4'b0, r[7:4] | r[3:0]};
      5: return s ? {3'b0, r[7], r[0], r[6]|r[4], r[5]|r[3], r[2]|r[1]}
                  : {3'b0, r[7], r[3], r[6]|r[2], r[5]|r[1], r[4]|r[0]};
      6: return s ? {2'b0, r[7], r[6], r[5]|r[3], r[4]|r[2], r[1], r[0]}
                  : {2'b0, r[7], r[6], r[5], r[4]|r[2], r[3]|r[1], r[0]};
      default: return s ? {1'b0, r[7], r[6]|r[5], r[4:0]}
                        : {1'b0, r[7:5], r[4]|r[3], r[2:0]};
    endcase
  endfunction

  // one accepted request; leaves the response visible at a falling edge
  task automatic send(input logic [15:0] a, input logic [7:0] u, input logic [7:0] pa,
                      input logic [7:0] px, input logic [7:0] ca, input logic [7:0] cx,
                      input logic fx);
    @(negedge clk);
    req_cpu_addr = a; req_user = u; req_prg_and = pa; req_prg_xor = px;
    req_chr_and = ca; req_chr_xor = cx; req_fixed_upper = fx;
    req_valid = 1'b1; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 rsp_valid", rsp_valid, 0);
    chk("R12 req_ready", req_ready, 1);
  endtask

  task automatic t_prg_basic();
    logic [7:0] us[4] = '{8'h3C, 8'hFF, 8'h00, 8'hA5};
    prg_rom_bits = 8; submapper = 0;
    foreach (us[i]) begin
      send(16'h8123, us[i], 8'h0F, 8'h90, 8'h00, 8'h00, 1'b0);
      chk("R1 valid", rsp_valid, 1);
      chk("R1 prg", rsp_prg_bank, (us[i] & 8'h0F) ^ 8'h90);
    end
  endtask

  task automatic t_chr_basic();
    chr_rom_bits = 8;
    send(16'h5000, 8'h6B, 8'hFF, 8'hFF, 8'hF0, 8'h0C, 1'b1);
    chk("R2 chr sup addr", rsp_chr_bank, (8'h6B & 8'hF0) ^ 8'h0C);
    send(16'hE000, 8'h6B, 8'h00, 8'h00, 8'h3F, 8'h81, 1'b1);
    chk("R2 chr fixed addr", rsp_chr_bank, (8'h6B & 8'h3F) ^ 8'h81);
  endtask

  task automatic t_fixed();
    prg_rom_bits = 8;
    send(16'hC000, 8'h12, 8'h7E, 8'h01, 0, 0, 1'b1);
    chk("R3 C000 fixed", rsp_prg_bank, 8'h7F);
    send(16'hFFFF, 8'h12, 8'h7E, 8'h01, 0, 0, 1'b1);
    chk("R3 FFFF fixed", rsp_prg_bank, 8'h7F);
    send(16'hBFFF, 8'h12, 8'h7E, 8'h01, 0, 0, 1'b1);
    chk("R3 BFFF fixed", rsp_prg_bank, (8'h12 & 8'h7E) ^ 8'h01);
    send(16'hC000, 8'h12, 8'h7E, 8'h01, 0, 0, 1'b0);
    chk("R3 C000 unfixed", rsp_prg_bank, (8'h12 & 8'h7E) ^ 8'h01);
  endtask

  task automatic t_super();
    for (int w = 0; w <= 8; w += 4) begin
      prg_rom_bits = 4'(w);
      send(16'h5ABC, 8'hFF, 8'hFF, 8'h5A, 8'hFF, 8'h00, 1'b0);
      chk("R4 sup prg", rsp_prg_bank, 0);
    end
    chk("R4 sup chr", rsp_chr_bank, 8'hFF);
    prg_rom_bits = 8;
  endtask

  task automatic t_subfield();
    prg_rom_bits = 2; chr_rom_bits = 2; submapper = 4'b0100;
    send(16'h8000, 8'h00, 8'h00, 8'h80, 8'h00, 8'h80, 1'b0);
    chk("R5 prg sub1", rsp_prg_bank, 8'h02);
    chk("R5 chr sub0", rsp_chr_bank, 8'h02);
    send(16'h8000, 8'h00, 8'h00, 8'h08, 8'h00, 8'h08, 1'b0);
    chk("R5 prg sub1 low", rsp_prg_bank, 8'h01);
    chk("R5 chr sub0 low", rsp_chr_bank, 8'h02);
  endtask

  task automatic t_edges();
    submapper = 0; prg_rom_bits = 0;
    send(16'h8000, 0, 0, 8'hFF, 0, 0, 1'b0);
    chk("R6 width0", rsp_prg_bank, 0);
    prg_rom_bits = 1;
    send(16'h8000, 0, 0, 8'h00, 0, 0, 1'b0);
    chk("R6 width1 clear", rsp_prg_bank, 0);
    send(16'h8000, 0, 0, 8'h10, 0, 0, 1'b0);
    chk("R6 width1 set", rsp_prg_bank, 1);
    prg_rom_bits = 8;
    send(16'h8000, 0, 0, 8'hC3, 0, 0, 1'b0);
    chk("R6 width8", rsp_prg_bank, 8'hC3);
    prg_rom_bits = 12;
    send(16'h8000, 0, 0, 8'hC3, 0, 0, 1'b0);
    chk("R9 width12", rsp_prg_bank, 8'hC3);
  endtask

  // walk one-hot and dense values through the XOR mask
  task automatic walk(input string tag, input int w, input int s);
    prg_rom_bits = 4'(w); submapper = {2'(s), 2'b00};
    for (int b = 0; b < 10; b++) begin
      logic [7:0] v = (b < 8) ? (8'h01 << b) : ((b == 8) ? 8'hA6 : 8'h59);
      send(16'h9000, 8'hFF, 8'h00, v, 0, 0, 1'b0);
      chk(tag, rsp_prg_bank, ref_fold(v, w, s));
    end
  endtask

  task automatic t_w2();
    walk("R7 w2s0", 2, 0);
    walk("R7 w2s1", 2, 1);
  endtask

  task automatic t_wide();
    for (int w = 3; w <= 7; w++)
      for (int s = 0; s < 2; s++) walk("R8 fold", w, s);
  endtask

  task automatic t_trunc();
    for (int w = 1; w <= 7; w += 3)
      for (int s = 2; s < 4; s++) walk("R9 trunc", w, s);
  endtask

  task automatic t_chr_ram();
    chr_rom_bits = 0; chr_ram_fitted = 1; submapper = 0;
    send(16'h8000, 0, 0, 0, 8'h00, 8'h04, 1'b0);
    chk("R10 ram set", rsp_chr_ram, 1);
    chk("R10 bank0", rsp_chr_bank, 0);
    send(16'h8000, 0, 0, 0, 8'h00, 8'h00, 1'b0);
    chk("R10 ram clear", rsp_chr_ram, 0);
    chr_ram_fitted = 0;
    send(16'h8000, 0, 0, 0, 8'h00, 8'h04, 1'b0);
    chk("R10 no ram", rsp_chr_ram, 0);
    chr_ram_fitted = 1; submapper = 4'b0001;
    send(16'h8000, 0, 0, 0, 8'h00, 8'h04, 1'b0);
    chk("R10 sub1", rsp_chr_ram, 0);
    chr_rom_bits = 3; submapper = 0;
    send(16'h8000, 0, 0, 0, 8'h00, 8'h04, 1'b0);
    chk("R10 rom fitted", rsp_chr_ram, 0);
    chr_ram_fitted = 0; chr_rom_bits = 8;
  endtask

  task automatic t_backpressure();
    prg_rom_bits = 8; submapper = 0;
    @(negedge clk);
    req_cpu_addr = 16'h8000; req_user = 8'hFF; req_prg_and = 8'h00; req_prg_xor = 8'h11;
    req_valid = 1; rsp_ready = 0;
    @(posedge clk); @(negedge clk);
    chk("R11 valid A", rsp_valid, 1);
    chk("R11 ready low", req_ready, 0);
    req_prg_xor = 8'h22;
    repeat (2) @(negedge clk);
    chk("R11 hold A", rsp_prg_bank, 8'h11);
    chk("R11 still valid", rsp_valid, 1);
    rsp_ready = 1;
    #1 chk("R11 ready follows", req_ready, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R11 B arrives", rsp_prg_bank, 8'h22);
    @(posedge clk); @(negedge clk);
    chk("R11 drained", rsp_valid, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prg_basic();
    t_chr_basic();
    t_fixed();
    t_super();
    t_subfield();
    t_edges();
    t_w2();
    t_wide();
    t_trunc();
    t_chr_ram();
    t_backpressure();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule